// File: doc/BRIEF.md
# Interrupt Entry and Far Return Sequencer

This block carries out the memory work behind two control transfers of a segmented 16-bit processor. The first is entry into an interrupt handler of a given type number, 0 to 255. The second is a far return from a subroutine. The execution unit gives it one start strobe, the operation kind and a snapshot of FLAGS, CS, IP, SS and SP. The block then issues a series of 16-bit word accesses on a single memory port. When it finishes, it presents the new CS, IP, SP and FLAGS and raises a one-cycle done pulse.

For an interrupt, the block saves the current state on the stack. It saves FLAGS first, then the return CS, then the return IP. Each save moves SP down by two bytes before the write. The block then loads the handler address from the vector table in segment 0, where each type takes four bytes. It clears the interrupt-enable and trap bits in the FLAGS value it returns. Type numbers 0 to 4 are the fixed internal causes: divide error, single step, non-maskable interrupt, breakpoint and overflow. Types 32 to 255 are free for external and software use. The sequencer handles all 256 types the same way.

For a far return, the block pops IP and then CS. It moves SP up by two bytes after each pop. It then adds an optional byte count to SP, which releases the arguments the caller pushed.

The memory port is a valid/ready stream. The block asserts `mem_req` (valid) together with the address, direction and write data. The memory accepts the access by raising `mem_ack` (ready) in the same cycle. The access completes on the clock edge where both are high. Until then, the block holds every request field steady. The memory may delay `mem_ack` for any number of cycles, and the block does not advance until it arrives.

Top module: `isr_far_ret_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low, and `cs_out`, `ip_out`, `sp_out` and `flags_out` are zero.
- R2: When `op_kind` is 0 (interrupt entry), the first three accesses are writes in this order: FLAGS to SP-2, return CS to SP-4, then return IP to SP-6, all in the stack segment. Each write goes to the address SP has after its decrement. The final `sp_out` is the input SP minus 6, modulo 2^16.
- R3: After the three writes, interrupt entry makes two reads in segment 0. It reads `ip_out` from offset type*4, then `cs_out` from offset type*4+2.
- R4: After interrupt entry, `flags_out` equals the input FLAGS with bit 9 (interrupt enable) and bit 8 (trap) cleared. All other bits are unchanged. The FLAGS word written to the stack is the unmodified input.
- R5: When `op_kind` is 1 (far return), the block makes only reads. It reads IP from SS:SP and then CS from SS:SP+2. The final `sp_out` is SP+4+`ret_adj` modulo 2^16, and `flags_out` equals the input FLAGS.
- R6: Every physical address equals segment*16 + offset modulo 2^20. Offsets wrap modulo 2^16 before this addition.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle. The block moves to its next access only on a cycle where both are high.
- R8: The block ignores `start` while `busy` is high. The access sequence and results of the operation in flight do not change.
- R9: `done` is high for exactly one cycle, in the cycle right after the last access completes. The outputs hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_kind | input | 1 | 0 = interrupt entry, 1 = far return |
| int_type | input | 8 | Interrupt type number |
| ret_adj | input | 16 | Extra bytes added to SP after a far return |
| flags_in | input | 16 | Current FLAGS |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current (return) instruction pointer |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory ready; access completes when high with mem_req |
| mem_rdata | input | 16 | Read data, valid in the acknowledge cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_out | output | 16 | Resulting CS |
| ip_out | output | 16 | Resulting IP |
| sp_out | output | 16 | Resulting SP |
| flags_out | output | 16 | Resulting FLAGS |

## Verification
The bench builds the block with its defaults: a 16-bit data path, a 4-bit segment shift, a 20-bit physical address and 8-bit type numbers. These values put both ends of the type range within reach. Type 255 places the vector at the top of the 1 KB table. They also allow an SP near zero to wrap inside the 16-bit offset, and a stack segment of FFFFh to overflow past 20 bits. The memory model acknowledges after a varying delay of zero to two cycles, which exercises the hold rules. One run also raises a second start strobe mid-sequence.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;

  // Sequencer steps; push/pop order is part of the behaviour
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_PUSH_FL = 4'd1,
    ST_PUSH_CS = 4'd2,
    ST_PUSH_IP = 4'd3,
    ST_VEC_IP  = 4'd4,
    ST_VEC_CS  = 4'd5,
    ST_POP_IP  = 4'd6,
    ST_POP_CS  = 4'd7,
    ST_FIN     = 4'd8
  } seq_state_e;

  typedef enum logic {
    OP_INT = 1'b0,
    OP_RET = 1'b1
  } seq_op_e;

endpackage

// File: rtl/isr_addr_gen.sv
module isr_addr_gen #(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PADDR_W   = 20
) (
  input  logic [DATA_W-1:0]  seg,
  input  logic [DATA_W-1:0]  off,
  output logic [PADDR_W-1:0] paddr
);

  localparam int SUM_W  = DATA_W + SEG_SHIFT;
  localparam int FULL_W = (SUM_W > PADDR_W) ? SUM_W : PADDR_W;

  logic [FULL_W-1:0] seg_ext;
  logic [FULL_W-1:0] off_ext;
  logic [FULL_W-1:0] sum;

  assign seg_ext = FULL_W'(seg) << SEG_SHIFT;
  assign off_ext = FULL_W'(off);
  assign sum     = seg_ext + off_ext;

  generate
    if (FULL_W > PADDR_W) begin : g_trunc
      logic [FULL_W-PADDR_W-1:0] dropped;
      assign dropped = sum[FULL_W-1:PADDR_W];
      assign paddr   = sum[PADDR_W-1:0];
    end else begin : g_exact
      assign paddr = sum;
    end
  endgenerate

endmodule

// File: rtl/isr_step_decode.sv
module isr_step_decode
  import isr_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TYPE_W    = 8,
  parameter int VEC_SHIFT = 2
) (
  input  seq_state_e         state,
  input  logic [DATA_W-1:0]  sp_q,
  input  logic [DATA_W-1:0]  flags_q,
  input  logic [DATA_W-1:0]  cs_q,
  input  logic [DATA_W-1:0]  ip_q,
  input  logic [TYPE_W-1:0]  type_q,
  output logic               acc,
  output logic               we,
  output logic               use_stack,
  output logic [DATA_W-1:0]  off,
  output logic [DATA_W-1:0]  wdata,
  output seq_state_e         nxt
);

  localparam logic [DATA_W-1:0] WORD_B = DATA_W'(2);

  logic [DATA_W-1:0] vec_base;
  logic [DATA_W-1:0] push_off;

  assign vec_base = DATA_W'(type_q) << VEC_SHIFT;
  assign push_off = sp_q - WORD_B;

  always_comb begin
    acc       = 1'b0;
    we        = 1'b0;
    use_stack = 1'b1;
    off       = sp_q;
    wdata     = '0;
    nxt       = state;
    unique case (state)
      ST_PUSH_FL: begin
        acc = 1'b1; we = 1'b1; off = push_off; wdata = flags_q; nxt = ST_PUSH_CS;
      end
      ST_PUSH_CS: begin
        acc = 1'b1; we = 1'b1; off = push_off; wdata = cs_q; nxt = ST_PUSH_IP;
      end
      ST_PUSH_IP: begin
        acc = 1'b1; we = 1'b1; off = push_off; wdata = ip_q; nxt = ST_VEC_IP;
      end
      ST_VEC_IP: begin
        acc = 1'b1; use_stack = 1'b0; off = vec_base; nxt = ST_VEC_CS;
      end
      ST_VEC_CS: begin
        acc = 1'b1; use_stack = 1'b0; off = vec_base + WORD_B; nxt = ST_FIN;
      end
      ST_POP_IP: begin
        acc = 1'b1; off = sp_q; nxt = ST_POP_CS;
      end
      ST_POP_CS: begin
        acc = 1'b1; off = sp_q; nxt = ST_FIN;
      end
      default: begin
        nxt = state;
      end
    endcase
  end

endmodule

// File: rtl/isr_far_ret_seq.sv
module isr_far_ret_seq
  import isr_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PADDR_W   = 20,
  parameter int TYPE_W    = 8,
  parameter int VEC_SHIFT = 2,
  parameter int IE_BIT    = 9,
  parameter int TRAP_BIT  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_kind,
  input  logic [TYPE_W-1:0]  int_type,
  input  logic [DATA_W-1:0]  ret_adj,
  input  logic [DATA_W-1:0]  flags_in,
  input  logic [DATA_W-1:0]  cs_in,
  input  logic [DATA_W-1:0]  ip_in,
  input  logic [DATA_W-1:0]  ss_in,
  input  logic [DATA_W-1:0]  sp_in,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  cs_out,
  output logic [DATA_W-1:0]  ip_out,
  output logic [DATA_W-1:0]  sp_out,
  output logic [DATA_W-1:0]  flags_out
);

  localparam logic [DATA_W-1:0] WORD_B   = DATA_W'(2);
  localparam logic [DATA_W-1:0] CLR_MASK = (DATA_W'(1) << IE_BIT) | (DATA_W'(1) << TRAP_BIT);
  localparam int                TBL_TOP  = TYPE_W + VEC_SHIFT;

  seq_state_e        state_q;
  seq_state_e        nxt_step;
  seq_op_e           op_q;
  logic [TYPE_W-1:0] type_q;
  logic [DATA_W-1:0] adj_q, flags_q, cs_q, ip_q, ss_q, sp_q;

  logic              acc, we, use_stack;
  logic [DATA_W-1:0] off, wdata, seg;
  logic              xfer;

  isr_step_decode #(
    .DATA_W(DATA_W), .TYPE_W(TYPE_W), .VEC_SHIFT(VEC_SHIFT)
  ) i_dec (
    .state(state_q), .sp_q(sp_q), .flags_q(flags_q), .cs_q(cs_q),
    .ip_q(ip_q), .type_q(type_q), .acc(acc), .we(we),
    .use_stack(use_stack), .off(off), .wdata(wdata), .nxt(nxt_step)
  );

  assign seg = use_stack ? ss_q : '0;

  isr_addr_gen #(
    .DATA_W(DATA_W), .SEG_SHIFT(SEG_SHIFT), .PADDR_W(PADDR_W)
  ) i_agen (
    .seg(seg), .off(off), .paddr(mem_addr)
  );

  assign mem_req   = acc;
  assign mem_we    = we;
  assign mem_wdata = wdata;
  assign xfer      = acc && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_INT;
      type_q  <= '0;
      adj_q   <= '0;
      flags_q <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= seq_op_e'(op_kind);
            type_q  <= int_type;
            adj_q   <= ret_adj;
            flags_q <= flags_in;
            cs_q    <= cs_in;
            ip_q    <= ip_in;
            ss_q    <= ss_in;
            sp_q    <= sp_in;
            state_q <= op_kind ? ST_POP_IP : ST_PUSH_FL;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: begin
          if (xfer) begin
            state_q <= nxt_step;
            unique case (state_q)
              ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: sp_q <= sp_q - WORD_B;
              ST_VEC_IP: ip_q <= mem_rdata;
              ST_VEC_CS: begin
                cs_q    <= mem_rdata;
                flags_q <= flags_q & ~CLR_MASK;
              end
              ST_POP_IP: begin
                ip_q <= mem_rdata;
                sp_q <= sp_q + WORD_B;
              end
              ST_POP_CS: begin
                cs_q <= mem_rdata;
                sp_q <= sp_q + WORD_B + adj_q;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign cs_out    = cs_q;
  assign ip_out    = ip_q;
  assign sp_out    = sp_q;
  assign flags_out = flags_q;

  // R1: an idle sequencer neither requests memory nor signals completion
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  // R2: every completed write lowers SP by one word
  a_r2_push_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we) |=> (sp_out == $past(sp_out) - WORD_B));

  // R3: vector reads stay inside the table in segment 0
  a_r3_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && op_q == OP_INT) |-> ((mem_addr >> TBL_TOP) == '0));

  // R4: interrupt completion leaves IE and trap cleared
  a_r4_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_INT) |-> ((flags_out & CLR_MASK) == '0));

  // R5: a far return never writes
  a_r5_return_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && op_q == OP_RET) |-> !mem_we);

  // R7: an unaccepted request keeps its fields
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R8: a start seen while busy leaves the operation kind alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));

  // R9: completion pulse is one cycle wide
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_isr_far_ret_seq.sv
module test_isr_far_ret_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_kind = 1'b0;
  logic [7:0]  int_type = '0;
  logic [15:0] ret_adj = '0, flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic        busy, done;
  logic [15:0] cs_out, ip_out, sp_out, flags_out;

  always #5 clk = ~clk;

  isr_far_ret_seq i_isr_far_ret_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .int_type(int_type), .ret_adj(ret_adj), .flags_in(flags_in),
    .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .cs_out(cs_out), .ip_out(ip_out),
    .sp_out(sp_out), .flags_out(flags_out)
  );

  typedef struct {
    logic [19:0] a;
    logic        w;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] mem [int];
  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;
  int          last_ack_cyc = 0;
  int          lat = 0;
  int          lfsr = 5;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic [31:0] act, input logic [31:0] expv,
                     input string req, input string what);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] t;
    t = ({5'b0, s} << 4) + {5'b0, o};
    return t[19:0];
  endfunction

  // Memory model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (lat == 0) begin
        if (exp_q.size() == 0) begin
          chk(32'(mem_addr), 32'hFFFFFFFF, "R7", "unexpected access");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(32'(mem_addr), 32'(e.a), e.tag, "access address");
          chk(32'(mem_we), 32'(e.w), e.tag, "access direction");
          if (e.w) chk(32'(mem_wdata), 32'(e.d), e.tag, "write data");
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
        mem_ack = 1'b1;
        last_ack_cyc = cyc;
        lfsr = (lfsr * 13 + 7) % 31;
        lat = lfsr % 3;
      end else begin
        mem_ack = 1'b0;
        lat = lat - 1;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic expect_acc(input logic [19:0] a, input logic w,
                            input logic [15:0] d, input string tag);
    exp_t e;
    e.a = a; e.w = w; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_done(input bit inject, input string tag);
    int k;
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      if (inject && k == 2) begin
        start = 1'b1; op_kind = 1'b1; sp_in = 16'h1234; ss_in = 16'h4444;
        int_type = 8'h77; flags_in = 16'h0F0F;
      end else begin
        start = 1'b0;
      end
      k++;
    end
    start = 1'b0;
    chk(32'(done), 32'd1, tag, "done reached");
    chk(32'(cyc), 32'(last_ack_cyc + 1), "R9", "done one cycle after last ack");
    chk(32'(exp_q.size()), 32'd0, tag, "all accesses made");
  endtask

  task automatic check_results(input logic [15:0] ecs, eip, esp, efl,
                               input string tag);
    chk(32'(cs_out), 32'(ecs), tag, "cs_out");
    chk(32'(ip_out), 32'(eip), tag, "ip_out");
    chk(32'(sp_out), 32'(esp), tag, "sp_out");
    chk(32'(flags_out), 32'(efl), tag, "flags_out");
    @(negedge clk);
    chk(32'(done), 32'd0, "R9", "done falls after one cycle");
    @(negedge clk);
    chk(32'(cs_out), 32'(ecs), "R9", "cs held");
    chk(32'(sp_out), 32'(esp), "R9", "sp held");
  endtask

  task automatic run_int(input logic [7:0] ty, input logic [15:0] fl, cs, ip, ss, sp,
                         input logic [15:0] vip, vcs, input bit inject, input string tag);
    logic [15:0] v;
    v = {6'b0, ty, 2'b0};
    mem[int'(v)] = vip;
    mem[int'(v + 16'd2)] = vcs;
    expect_acc(phys(ss, sp - 16'd2), 1'b1, fl, "R2");
    expect_acc(phys(ss, sp - 16'd4), 1'b1, cs, "R2");
    expect_acc(phys(ss, sp - 16'd6), 1'b1, ip, "R2");
    expect_acc({4'b0, v}, 1'b0, 16'h0, "R3");
    expect_acc({4'b0, v + 16'd2}, 1'b0, 16'h0, "R3");
    @(negedge clk);
    op_kind = 1'b0; int_type = ty; flags_in = fl; cs_in = cs; ip_in = ip;
    ss_in = ss; sp_in = sp; start = 1'b1;
    wait_done(inject, tag);
    check_results(vcs, vip, sp - 16'd6, fl & 16'hFCFF, tag);
  endtask

  task automatic run_ret(input logic [15:0] fl, ss, sp, adj, rip, rcs, input string tag);
    mem[int'(phys(ss, sp))] = rip;
    mem[int'(phys(ss, sp + 16'd2))] = rcs;
    expect_acc(phys(ss, sp), 1'b0, 16'h0, "R5");
    expect_acc(phys(ss, sp + 16'd2), 1'b0, 16'h0, "R5");
    @(negedge clk);
    op_kind = 1'b1; int_type = 8'h00; flags_in = fl; cs_in = 16'hDEAD; ip_in = 16'hBEEF;
    ss_in = ss; sp_in = sp; ret_adj = adj; start = 1'b1;
    wait_done(1'b0, tag);
    check_results(rcs, rip, sp + 16'd4 + adj, fl, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(32'(busy), 32'd0, "R1", "busy after reset");
    chk(32'(done), 32'd0, "R1", "done after reset");
    chk(32'(mem_req), 32'd0, "R1", "mem_req after reset");
    chk(32'({cs_out, ip_out}), 32'd0, "R1", "cs/ip after reset");
    chk(32'({sp_out, flags_out}), 32'd0, "R1", "sp/flags after reset");

    // R2 R3 R4: type 0, IE and trap set
    run_int(8'd0, 16'h0302, 16'h1100, 16'h0456, 16'h2000, 16'h0100, 16'hA000, 16'hF000, 1'b0, "R4");
    // R6: type 255 with SP wrapping below zero
    run_int(8'd255, 16'hFFFF, 16'h2222, 16'h3333, 16'h0500, 16'h0004, 16'h1357, 16'h2468, 1'b0, "R6");
    // R8: start strobe injected while busy
    run_int(8'd3, 16'h0200, 16'h7000, 16'h0010, 16'h9000, 16'hFF00, 16'h0BAD, 16'h0C0D, 1'b1, "R8");
    // R2: overflow type, high stack segment
    run_int(8'd4, 16'h0100, 16'hC000, 16'h8888, 16'hF000, 16'h8000, 16'h4321, 16'h8765, 1'b0, "R2");
    // R5: plain far return
    run_ret(16'h0246, 16'h3000, 16'h0200, 16'h0000, 16'h1111, 16'h2222, "R5");
    // R6: far return with adjust, offset and 20-bit wrap
    run_ret(16'h0302, 16'hFFFF, 16'hFFFE, 16'h0006, 16'h5A5A, 16'hA5A5, "R6");
    // R3: software type in free range
    run_int(8'd32, 16'h0000, 16'h0001, 16'h0002, 16'h0040, 16'h0030, 16'hCAFE, 16'hF00D, 1'b0, "R3");

    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule